// File: doc/BRIEF.md
# Floating-Point Predicate Comparator

This block compares two IEEE-754 floating-point operands and evaluates one of ten comparison predicates on them in a single combinational pass. The predicate select chooses between ordered forms, unordered forms and signalling relational forms. The block returns a one-bit predicate result and a one-bit invalid-operation indication. A caller forms derived predicates such as greater-than outside the block, by swapping the operands or inverting the result. The caller also accumulates the invalid indication into sticky state.

The operand format is set by two parameters: exponent width and mantissa width. The defaults give binary32, and 5/10 gives binary16. Each operand is classified independently as not-a-number, signalling or zero. For non-NaN operands the ordering follows sign-magnitude rules, in which both zeros are equal. A parameter picks one of two ways to build that ordering: a direct sign-aware magnitude compare, or a mapping of each operand to an unsigned sort key. Each predicate has its own rule for when the invalid flag is raised.

Top module: `fcmp_top`

## Requirements
- R1: An operand is NaN when every exponent bit is 1 and the mantissa is nonzero. A NaN is signalling when the top mantissa bit (bit MAN_W-1) is 0 and quiet when that bit is 1.
- R2: The predicate codes are 0 oeq, 1 olt, 2 ole, 3 ueq, 4 ult, 5 ule, 6 un, 7 uneq, 8 uleq and 9 ultq. The predicates oeq, olt and ole give result 0 whenever either operand is NaN.
- R3: The predicates ueq, ult, ule, un, uneq, uleq and ultq give result 1 whenever either operand is NaN.
- R4: For oeq, ueq, ult, ule, un and uneq, invalid is 1 exactly when at least one operand is a signalling NaN.
- R5: For olt, ole, uleq and ultq, invalid is 1 exactly when at least one operand is a NaN of either kind.
- R6: Negative zero and positive zero compare equal. For the pair (-0, +0), oeq, ole, ueq and ule give 1, and olt and ult give 0.
- R7: With no NaN present, operands are ordered by value: a negative compares below a positive, two negatives compare in reverse order of magnitude, and infinities are the extremes. The predicates eq, lt and le then give equal, less-than and less-or-equal; uleq equals le and ultq equals lt.
- R8: uneq gives 1 when the operands are unordered or unequal. un gives 1 only when they are unordered.
- R9: Codes 10 to 15 give result 0 and invalid 0 for every operand pair.
- R10: Both ordering implementations (ORDER_IMPL 0 and 1) give identical outputs for every operand pair and code. The block accepts any format with exponent width of at least 2 and mantissa width of at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | EXP_W+MAN_W+1 | First operand (sign, exponent, mantissa) |
| op_b | input | EXP_W+MAN_W+1 | Second operand |
| pred_sel | input | 4 | Predicate code, 0 to 9 used |
| pred_true | output | 1 | Predicate result |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The hardest situations to reach are the narrow ones: a signalling NaN against a quiet NaN, both zeros against each other, and a pair of negative infinities under each predicate. In a wide format, random stimulus almost never lands on these. The bench therefore builds two extra instances in a six-bit format, one for each ordering implementation. It sweeps every operand pair against every one of the sixteen codes, so each class pair, each zero-sign combination and each unused code is covered exhaustively. A default binary32 instance then takes directed single- and double-class cases.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;

   localparam int unsigned PRED_W = 4;

   typedef enum logic [PRED_W-1:0] {
      CMP_OEQ  = 4'd0,
      CMP_OLT  = 4'd1,
      CMP_OLE  = 4'd2,
      CMP_UEQ  = 4'd3,
      CMP_ULT  = 4'd4,
      CMP_ULE  = 4'd5,
      CMP_UN   = 4'd6,
      CMP_UNEQ = 4'd7,
      CMP_ULEQ = 4'd8,
      CMP_ULTQ = 4'd9
   } cmp_pred_e;

   // Per-operand class summary
   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_nan;
      logic is_snan;
   } fcls_t;

   // Pair summary fed to the predicate stage
   typedef struct packed {
      logic unord;
      logic any_snan;
      logic lt;
      logic eq;
   } frel_t;

   // Predicates whose invalid rule fires on any NaN
   function automatic logic pred_loud(input cmp_pred_e p);
      return (p == CMP_OLT) || (p == CMP_OLE) || (p == CMP_ULEQ) || (p == CMP_ULTQ);
   endfunction

endpackage

// File: rtl/fcmp_classify.sv
`timescale 1ns/1ps
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned OP_W  = EXP_W + MAN_W + 1,
   localparam int unsigned MAG_W = EXP_W + MAN_W
) (
   input  logic [OP_W-1:0]  op,
   output fcls_t            cls,
   output logic [MAG_W-1:0] mag
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             exp_zero;
   logic             man_nz;

   always_comb begin
      exp_f    = op[MAN_W +: EXP_W];
      man_f    = op[MAN_W-1:0];
      exp_ones = &exp_f;
      exp_zero = ~|exp_f;
      man_nz   = |man_f;

      cls.sign    = op[OP_W-1];
      cls.is_zero = exp_zero & ~man_nz;
      cls.is_nan  = exp_ones & man_nz;
      cls.is_snan = exp_ones & man_nz & ~man_f[MAN_W-1];
      mag         = op[MAG_W-1:0];
   end

endmodule

// File: rtl/fcmp_order.sv
`timescale 1ns/1ps
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W      = 8,
   parameter int unsigned MAN_W      = 23,
   parameter int unsigned ORDER_IMPL = 0,
   localparam int unsigned MAG_W = EXP_W + MAN_W
) (
   input  fcls_t            cls_a,
   input  fcls_t            cls_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             lt,
   output logic             eq
);

   generate
      if (ORDER_IMPL == 0) begin : g_signmag
         // Direct sign-aware magnitude comparison
         logic mag_lt;
         logic mag_eq;
         logic both_zero;
         always_comb begin
            mag_lt    = mag_a < mag_b;
            mag_eq    = mag_a == mag_b;
            both_zero = cls_a.is_zero & cls_b.is_zero;
            if (both_zero) begin
               lt = 1'b0;
               eq = 1'b1;
            end else if (cls_a.sign != cls_b.sign) begin
               lt = cls_a.sign;
               eq = 1'b0;
            end else if (cls_a.sign) begin
               lt = ~mag_lt & ~mag_eq;
               eq = mag_eq;
            end else begin
               lt = mag_lt;
               eq = mag_eq;
            end
         end
      end else begin : g_sortkey
         // Map each operand onto an unsigned key whose order is the value order
         logic [MAG_W:0] key_a;
         logic [MAG_W:0] key_b;
         always_comb begin
            if (cls_a.is_zero)   key_a = {1'b1, {MAG_W{1'b0}}};
            else if (cls_a.sign) key_a = {1'b0, ~mag_a};
            else                 key_a = {1'b1, mag_a};
            if (cls_b.is_zero)   key_b = {1'b1, {MAG_W{1'b0}}};
            else if (cls_b.sign) key_b = {1'b0, ~mag_b};
            else                 key_b = {1'b1, mag_b};
            lt = key_a < key_b;
            eq = key_a == key_b;
         end
      end
   endgenerate

endmodule

// File: rtl/fcmp_select.sv
`timescale 1ns/1ps
module fcmp_select
   import fcmp_pkg::*;
(
   input  logic [PRED_W-1:0] pred_sel,
   input  frel_t             rel,
   output logic              pred_true,
   output logic              invalid
);

   cmp_pred_e pred;
   logic      known;

   always_comb begin
      pred  = cmp_pred_e'(pred_sel);
      known = pred_sel <= PRED_W'(CMP_ULTQ);

      case (pred_sel)
         CMP_OEQ:  pred_true = ~rel.unord & rel.eq;
         CMP_OLT:  pred_true = ~rel.unord & rel.lt;
         CMP_OLE:  pred_true = ~rel.unord & (rel.lt | rel.eq);
         CMP_UEQ:  pred_true = rel.unord | rel.eq;
         CMP_ULT:  pred_true = rel.unord | rel.lt;
         CMP_ULE:  pred_true = rel.unord | rel.lt | rel.eq;
         CMP_UN:   pred_true = rel.unord;
         CMP_UNEQ: pred_true = rel.unord | ~rel.eq;
         CMP_ULEQ: pred_true = rel.unord | rel.lt | rel.eq;
         CMP_ULTQ: pred_true = rel.unord | rel.lt;
         default:  pred_true = 1'b0;
      endcase

      if (!known)               invalid = 1'b0;
      else if (pred_loud(pred)) invalid = rel.unord;
      else                      invalid = rel.any_snan;
   end

endmodule

// File: rtl/fcmp_top.sv
`timescale 1ns/1ps
module fcmp_top
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W      = 8,
   parameter int unsigned MAN_W      = 23,
   parameter int unsigned ORDER_IMPL = 0,
   localparam int unsigned OP_W  = EXP_W + MAN_W + 1,
   localparam int unsigned MAG_W = EXP_W + MAN_W,
   localparam int unsigned N_OPS = 2
) (
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   input  logic [PRED_W-1:0] pred_sel,
   output logic              pred_true,
   output logic              invalid
);

   // Elaboration-time parameter checks
   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fcmp_top: EXP_W must be at least 2");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("fcmp_top: MAN_W must be at least 2");
      end
      if (ORDER_IMPL > 1) begin : g_bad_impl
         $error("fcmp_top: ORDER_IMPL must be 0 or 1");
      end
   endgenerate

   logic [OP_W-1:0]  ops  [N_OPS];
   fcls_t            cls  [N_OPS];
   logic [MAG_W-1:0] mags [N_OPS];
   frel_t            rel;
   logic             ord_lt;
   logic             ord_eq;

   always_comb begin
      ops[0] = op_a;
      ops[1] = op_b;
   end

   generate
      for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
         fcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
         ) u_cls (
            .op  (ops[gi]),
            .cls (cls[gi]),
            .mag (mags[gi])
         );
      end
   endgenerate

   fcmp_order #(
      .EXP_W      (EXP_W),
      .MAN_W      (MAN_W),
      .ORDER_IMPL (ORDER_IMPL)
   ) u_order (
      .cls_a (cls[0]),
      .cls_b (cls[1]),
      .mag_a (mags[0]),
      .mag_b (mags[1]),
      .lt    (ord_lt),
      .eq    (ord_eq)
   );

   always_comb begin
      rel.unord    = cls[0].is_nan  | cls[1].is_nan;
      rel.any_snan = cls[0].is_snan | cls[1].is_snan;
      rel.lt       = ord_lt;
      rel.eq       = ord_eq;
   end

   fcmp_select u_select (
      .pred_sel  (pred_sel),
      .rel       (rel),
      .pred_true (pred_true),
      .invalid   (invalid)
   );

endmodule

// File: rtl/fcmp_checker.sv
`timescale 1ns/1ps
module fcmp_checker #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned OP_W = EXP_W + MAN_W + 1
) (
   input logic [OP_W-1:0] op_a,
   input logic [OP_W-1:0] op_b,
   input logic [3:0]      pred_sel,
   input logic            pred_true,
   input logic            invalid
);

   function automatic logic chk_nan(input logic [OP_W-1:0] x);
      return (x[MAN_W +: EXP_W] == {EXP_W{1'b1}}) && (x[MAN_W-1:0] != '0);
   endfunction

   function automatic logic chk_snan(input logic [OP_W-1:0] x);
      return chk_nan(x) && !x[MAN_W-1];
   endfunction

   function automatic logic chk_zero(input logic [OP_W-1:0] x);
      return x[OP_W-2:0] == '0;
   endfunction

   logic nan_any;
   logic snan_any;
   logic ord_grp;
   logic unord_grp;
   logic quiet_grp;
   logic loud_grp;

   always_comb begin
      nan_any   = chk_nan(op_a) || chk_nan(op_b);
      snan_any  = chk_snan(op_a) || chk_snan(op_b);
      ord_grp   = pred_sel <= 4'd2;
      unord_grp = (pred_sel >= 4'd3) && (pred_sel <= 4'd9);
      quiet_grp = (pred_sel == 4'd0) || ((pred_sel >= 4'd3) && (pred_sel <= 4'd7));
      loud_grp  = (pred_sel == 4'd1) || (pred_sel == 4'd2) || (pred_sel == 4'd8) || (pred_sel == 4'd9);

      AST_ORD_FALSE_ON_NAN: assert final (!(ord_grp && nan_any) || !pred_true) else $error("ordered predicate true on NaN"); // R2
      AST_UNORD_TRUE_ON_NAN: assert final (!(unord_grp && nan_any) || pred_true) else $error("unordered predicate false on NaN"); // R3
      AST_QUIET_INV_SNAN: assert final (!quiet_grp || (invalid == snan_any)) else $error("quiet-family invalid mismatch"); // R4
      AST_LOUD_INV_ANY_NAN: assert final (!loud_grp || (invalid == nan_any)) else $error("signalling-family invalid mismatch"); // R5
      AST_ZERO_PAIR_EQ: assert final (!(pred_sel == 4'd0 && chk_zero(op_a) && chk_zero(op_b)) || pred_true) else $error("zeros not equal"); // R6
      AST_UN_IS_UNORD: assert final (!(pred_sel == 4'd6) || (pred_true == nan_any)) else $error("un result mismatch"); // R8
      AST_UNUSED_CODE_IDLE: assert final (!(pred_sel > 4'd9) || (!pred_true && !invalid)) else $error("unused code active"); // R9
   end

endmodule

bind fcmp_top fcmp_checker #(
   .EXP_W (EXP_W),
   .MAN_W (MAN_W)
) u_fcmp_checker (
   .op_a      (op_a),
   .op_b      (op_b),
   .pred_sel  (pred_sel),
   .pred_true (pred_true),
   .invalid   (invalid)
);

// File: tb/test_fcmp_top.sv
`timescale 1ns/1ps
module test_fcmp_top;

   localparam int SE = 3;
   localparam int SM = 2;
   localparam int SW = SE + SM + 1;
   localparam int WATCHDOG_CYCLES = 200000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Small-format instances, one per ordering implementation
   logic [SW-1:0] sa, sb;
   logic [3:0]    sp;
   logic          r0, i0, r1, i1;

   fcmp_top #(.EXP_W(SE), .MAN_W(SM), .ORDER_IMPL(0)) i_fcmp_top_s0 (
      .op_a(sa), .op_b(sb), .pred_sel(sp), .pred_true(r0), .invalid(i0));
   fcmp_top #(.EXP_W(SE), .MAN_W(SM), .ORDER_IMPL(1)) i_fcmp_top_s1 (
      .op_a(sa), .op_b(sb), .pred_sel(sp), .pred_true(r1), .invalid(i1));

   // Default binary32 instance
   logic [31:0] fa, fb;
   logic [3:0]  fp;
   logic        fr, fi;

   fcmp_top i_fcmp_top (
      .op_a(fa), .op_b(fb), .pred_sel(fp), .pred_true(fr), .invalid(fi));

   task automatic check(input bit got_r, input bit got_i, input bit exp_r, input bit exp_i,
                        input string req);
      n_tests++;
      if (got_r !== exp_r || got_i !== exp_i) begin
         n_fail++;
         $display("FAIL %s: got result=%0b invalid=%0b expected result=%0b invalid=%0b",
                  req, got_r, got_i, exp_r, exp_i);
      end
   endtask

   // Reference model for the six-bit format, computed from numeric value
   function automatic void ref_cmp(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                   input int p, output bit r, output bit inv);
      bit na, nb, sna, snb, un, sn, lt, eq;
      int va, vb;
      na  = (a[SW-2:SM] == 3'b111) && (a[SM-1:0] != 0);   // R1
      nb  = (b[SW-2:SM] == 3'b111) && (b[SM-1:0] != 0);
      sna = na && !a[SM-1];
      snb = nb && !b[SM-1];
      un  = na || nb;
      sn  = sna || snb;
      va  = a[SW-1] ? -int'(a[SW-2:0]) : int'(a[SW-2:0]);  // R6: both zeros give 0
      vb  = b[SW-1] ? -int'(b[SW-2:0]) : int'(b[SW-2:0]);  // R7: value order
      lt  = va < vb;
      eq  = va == vb;
      case (p)
         0: begin r = !un && eq;         inv = sn; end
         1: begin r = !un && lt;         inv = un; end
         2: begin r = !un && (lt || eq); inv = un; end
         3: begin r = un || eq;          inv = sn; end
         4: begin r = un || lt;          inv = sn; end
         5: begin r = un || lt || eq;    inv = sn; end
         6: begin r = un;                inv = sn; end
         7: begin r = un || !eq;         inv = sn; end
         8: begin r = un || lt || eq;    inv = un; end
         9: begin r = un || lt;          inv = un; end
         default: begin r = 1'b0;        inv = 1'b0; end   // R9
      endcase
   endfunction

   task automatic dir32(input logic [31:0] a, input logic [31:0] b, input int p,
                        input bit er, input bit ei, input string req);
      fa = a; fb = b; fp = 4'(p);
      #2;
      check(fr, fi, er, ei, req);
   endtask

   initial begin
      sa = '0; sb = '0; sp = '0;
      fa = '0; fb = '0; fp = '0;
      #3;
      // Reset-state style check: (+0, +0) under oeq
      check(fr, fi, 1'b1, 1'b0, "R6 initial zero pair");

      // Exhaustive sweep of the six-bit format across all codes, both implementations
      for (int p = 0; p < 16; p++) begin
         for (int a = 0; a < (1 << SW); a++) begin
            for (int b = 0; b < (1 << SW); b++) begin
               bit er, ei;
               sa = SW'(a); sb = SW'(b); sp = 4'(p);
               #1;
               ref_cmp(sa, sb, p, er, ei);
               check(r0, i0, er, ei, "R1-sweep R2 R3 R4 R5 R7 R8 impl0");
               check(r1, i1, er, ei, "R10 sweep impl1");
            end
         end
      end

      // Directed binary32 cases
      dir32(32'h3f800000, 32'h7fc00000, 1, 1'b0, 1'b1, "R5 olt(1,qNaN)");
      dir32(32'h3f800000, 32'h7fc00000, 0, 1'b0, 1'b0, "R4 oeq(1,qNaN)");
      dir32(32'h3f800000, 32'h7fa00000, 0, 1'b0, 1'b1, "R4 oeq(1,sNaN)");
      dir32(32'h3f800000, 32'h7fc00000, 3, 1'b1, 1'b0, "R3 ueq(1,qNaN)");
      dir32(32'h3f800000, 32'h7fc00000, 8, 1'b1, 1'b1, "R5 uleq(1,qNaN)");
      dir32(32'h7fbfffff, 32'h3f800000, 6, 1'b1, 1'b1, "R1 un(sNaN full payload,1)");
      dir32(32'h7f800000, 32'h3f800000, 6, 1'b0, 1'b0, "R1 un(+inf,1) not NaN");
      dir32(32'h80000000, 32'h00000000, 0, 1'b1, 1'b0, "R6 oeq(-0,+0)");
      dir32(32'h80000000, 32'h00000000, 1, 1'b0, 1'b0, "R6 olt(-0,+0)");
      dir32(32'h80000000, 32'h00000000, 4, 1'b0, 1'b0, "R6 ult(-0,+0)");
      dir32(32'hff800000, 32'hc0000000, 1, 1'b1, 1'b0, "R7 olt(-inf,-2)");
      dir32(32'hc0000000, 32'hbf800000, 1, 1'b1, 1'b0, "R7 olt(-2,-1)");
      dir32(32'h40000000, 32'h3f800000, 2, 1'b0, 1'b0, "R7 ole(2,1)");
      dir32(32'h3f800000, 32'h7f800000, 9, 1'b1, 1'b0, "R7 ultq(1,+inf)");
      dir32(32'h3f800000, 32'h40000000, 7, 1'b1, 1'b0, "R8 uneq(1,2)");
      dir32(32'h3f800000, 32'h3f800000, 7, 1'b0, 1'b0, "R8 uneq(1,1)");
      dir32(32'h3f800000, 32'h40000000, 6, 1'b0, 1'b0, "R8 un(1,2)");
      dir32(32'h7fa00000, 32'h7fc00000, 12, 1'b0, 1'b0, "R9 code 12 with NaNs");
      dir32(32'h3f800000, 32'h3f800000, 15, 1'b0, 1'b0, "R9 code 15 equal");
      dir32(32'h7fa00000, 32'h3f800000, 2, 1'b0, 1'b1, "R2 ole(sNaN,1)");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule